// File: doc/BRIEF.md
# Warp Memory Access Coalescer

The coalescer accepts one memory request covering a full group of parallel lanes. Each lane carries a byte address, a bit saying whether it takes part, and the request carries one access size that applies to every lane. The block sorts the taking-part lanes by the aligned 128-byte line that each address falls in. It then emits the smallest set of line transactions, one per cycle, so that a well-behaved access pattern costs a single line fetch and not one fetch per lane.

Every outgoing transaction carries the line address and a lane mask naming the lanes it serves. Both sides use a valid/ready handshake, so a slow memory side stalls the block without losing anything. A lane whose address is not a multiple of the access size is reported as misaligned and left out of every transaction. When a request has drained, the block gives a one-cycle completion report with the number of transactions issued and the mask of misaligned lanes.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready is 1 while txn_valid and done_valid are 0.
- R2: txn_line is the byte address of a lane it serves with the low 7 bits cleared, and every lane set in txn_lanes has an address in that 128-byte line.
- R3: 32 active lanes making 4-byte accesses to consecutive addresses that start on a line boundary produce exactly one transaction, whose mask is all ones and which has txn_last set.
- R4: A request produces one transaction per distinct line touched by its valid lanes. A run of consecutive 4-byte accesses that is offset by 64 bytes gives 2 transactions. A 12-byte stride gives 3.
- R5: Transactions come out in order of the lowest lane each one serves. Each transaction collects every not-yet-served valid lane that shares its line, so no lane appears in two transactions.
- R6: req_size encodes the access size as 0 = 4 bytes, 1 = 8 bytes and 2 = 16 bytes. An active lane whose address is not a multiple of that size sets its bit in done_misalign and joins no transaction. With code 3 every active lane is treated as misaligned.
- R7: Lanes whose req_mask bit is 0 are ignored. Their addresses affect neither the transactions nor done_misalign.
- R8: While txn_valid is 1 and txn_ready is 0, txn_line, txn_lanes and txn_last hold steady. The block moves to the next transaction only after a handshake.
- R9: req_ready drops in the cycle after a request is accepted. done_valid pulses for one cycle in the cycle after the last transaction handshake. req_ready is 1 again in the cycle after that pulse.
- R10: A request with no valid lanes issues no transaction and reports done_valid with done_count 0 in the cycle after it is accepted.
- R11: done_count equals the number of transactions handshaken for the request, and txn_last is set only on the final one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| req_mask | input | LANES | Lane taking-part mask |
| req_size | input | 2 | Access size code (0: 4 B, 1: 8 B, 2: 16 B) |
| txn_valid | output | 1 | Line transaction offered |
| txn_ready | input | 1 | Downstream accepts the transaction |
| txn_line | output | ADDR_W | Aligned line byte address |
| txn_lanes | output | LANES | Lanes served by this transaction |
| txn_last | output | 1 | Final transaction of the request |
| done_valid | output | 1 | One-cycle completion report |
| done_count | output | $clog2(LANES+1) | Transactions issued for the request |
| done_misalign | output | LANES | Lanes rejected as misaligned |

## Verification
The bench builds the block with its default parameters: 32 lanes, 32-bit addresses and 128-byte lines. This is the full lane width, so the bench can reach the all-lanes-in-one-line case, two- and three-line offsets and strides, and the worst case of 32 separate lines that drives done_count to its maximum. Interleaved line orders, partial masks with misaligned addresses on inactive lanes, the reserved size code and downstream stalls are compared against a grouping model that the bench computes for itself.

// File: rtl/warp_coalescer_pkg.sv
package warp_coalescer_pkg;

    typedef enum logic [0:0] {
        CO_IDLE = 1'b0,
        CO_BUSY = 1'b1
    } co_state_e;

    // Byte-offset mask for a size code; code 3 is reserved.
    function automatic logic [3:0] size_low_mask(input logic [1:0] code);
        case (code)
            2'd0:    size_low_mask = 4'b0011;
            2'd1:    size_low_mask = 4'b0111;
            default: size_low_mask = 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/warp_coalescer_screen.sv
module warp_coalescer_screen #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    parameter int OFS    = 7
) (
    input  logic [LANES*ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]              active,
    input  logic [1:0]                    size,
    output logic [LANES-1:0]              good,
    output logic [LANES-1:0]              bad,
    output logic [LANES*(ADDR_W-OFS)-1:0] tags
);
    import warp_coalescer_pkg::*;

    localparam int TAG_W = ADDR_W - OFS;

    logic [OFS-1:0] low_mask;
    logic           reserved;

    always_comb begin
        low_mask = '0;
        low_mask[3:0] = size_low_mask(size);
        reserved = (size == 2'd3);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [OFS-1:0] offs;
        logic           off_size;
        assign offs     = addr[i*ADDR_W +: OFS];
        assign off_size = reserved || ((offs & low_mask) != '0);
        assign bad[i]   = active[i] && off_size;
        assign good[i]  = active[i] && !off_size;
        assign tags[i*TAG_W +: TAG_W] = addr[i*ADDR_W + OFS +: TAG_W];
    end

endmodule

// File: rtl/warp_coalescer_pick.sv
module warp_coalescer_pick #(
    parameter int LANES = 32,
    parameter int TAG_W = 25
) (
    input  logic [LANES-1:0]       pend,
    input  logic [LANES*TAG_W-1:0] tags,
    output logic                   any,
    output logic [TAG_W-1:0]       lead_tag,
    output logic [LANES-1:0]       match
);
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [IDX_W-1:0] lead;

    // Lowest pending lane wins.
    always_comb begin
        lead = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) lead = IDX_W'(i);
        end
    end

    assign any      = (pend != '0);
    assign lead_tag = tags[lead*TAG_W +: TAG_W];

    for (genvar i = 0; i < LANES; i++) begin : g_cmp
        assign match[i] = pend[i] && (tags[i*TAG_W +: TAG_W] == lead_tag);
    end

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    localparam int OFS       = $clog2(LINE_BYTES),
    localparam int TAG_W     = ADDR_W - OFS,
    localparam int CNT_W     = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_mask,
    input  logic [1:0]              req_size,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_line,
    output logic [LANES-1:0]        txn_lanes,
    output logic                    txn_last,
    output logic                    done_valid,
    output logic [CNT_W-1:0]        done_count,
    output logic [LANES-1:0]        done_misalign
);
    import warp_coalescer_pkg::*;

    typedef struct packed {
        co_state_e              st;
        logic [LANES-1:0]       pend;
        logic [LANES-1:0]       bad;
        logic [CNT_W-1:0]       cnt;
        logic [LANES*TAG_W-1:0] tags;
    } co_regs_t;

    co_regs_t r_d, r_q;

    logic [LANES-1:0]       scr_good, scr_bad;
    logic [LANES*TAG_W-1:0] scr_tags;
    logic                   pk_any;
    logic [TAG_W-1:0]       pk_tag;
    logic [LANES-1:0]       pk_match;

    warp_coalescer_screen #(
        .LANES (LANES),
        .ADDR_W(ADDR_W),
        .OFS   (OFS)
    ) u_screen (
        .addr  (req_addr),
        .active(req_mask),
        .size  (req_size),
        .good  (scr_good),
        .bad   (scr_bad),
        .tags  (scr_tags)
    );

    warp_coalescer_pick #(
        .LANES(LANES),
        .TAG_W(TAG_W)
    ) u_pick (
        .pend    (r_q.pend),
        .tags    (r_q.tags),
        .any     (pk_any),
        .lead_tag(pk_tag),
        .match   (pk_match)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            CO_IDLE: begin
                if (req_valid) begin
                    r_d.st   = CO_BUSY;
                    r_d.pend = scr_good;
                    r_d.bad  = scr_bad;
                    r_d.cnt  = '0;
                    r_d.tags = scr_tags;
                end
            end
            default: begin
                if (pk_any) begin
                    if (txn_ready) begin
                        r_d.pend = r_q.pend & ~pk_match;
                        r_d.cnt  = r_q.cnt + CNT_W'(1);
                    end
                end else begin
                    r_d.st = CO_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: CO_IDLE, pend: '0, bad: '0, cnt: '0, tags: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == CO_IDLE);
    assign txn_valid     = (r_q.st == CO_BUSY) && pk_any;
    assign txn_line      = {pk_tag, {OFS{1'b0}}};
    assign txn_lanes     = pk_match;
    assign txn_last      = txn_valid && (pk_match == r_q.pend);
    assign done_valid    = (r_q.st == CO_BUSY) && !pk_any;
    assign done_count    = r_q.cnt;
    assign done_misalign = r_q.bad;

endmodule

// File: rtl/warp_coalescer_checker.sv
module warp_coalescer_checker #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    parameter int OFS    = 7,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              txn_valid,
    input logic              txn_ready,
    input logic [ADDR_W-1:0] txn_line,
    input logic [LANES-1:0]  txn_lanes,
    input logic              txn_last,
    input logic              done_valid,
    input logic [CNT_W-1:0]  done_count
);
    logic [CNT_W-1:0] seen_cnt;
    logic [LANES-1:0] served;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_cnt <= '0;
            served   <= '0;
        end else if (req_valid && req_ready) begin
            seen_cnt <= '0;
            served   <= '0;
        end else if (txn_valid && txn_ready) begin
            seen_cnt <= seen_cnt + CNT_W'(1);
            served   <= served | txn_lanes;
        end
    end

    assert_txn_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_line) && $stable(txn_lanes) && $stable(txn_last));

    assert_line_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_lanes != '0) && (txn_line[OFS-1:0] == '0));

    assert_busy_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid || done_valid) |-> !req_ready);

    assert_accept_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    assert_done_reopen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> req_ready && !done_valid);

    assert_last_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_ready && txn_last |=> done_valid);

    assert_count_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> done_count == seen_cnt);

    assert_no_reserve_R5: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_lanes & served) == '0);

endmodule

bind warp_coalescer warp_coalescer_checker #(
    .LANES (LANES),
    .ADDR_W(ADDR_W),
    .OFS   (OFS),
    .CNT_W (CNT_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_line  (txn_line),
    .txn_lanes (txn_lanes),
    .txn_last  (txn_last),
    .done_valid(done_valid),
    .done_count(done_count)
);

// File: tb/warp_coalescer_bench.sv
module warp_coalescer_bench;
    localparam int LANES  = 32;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = $clog2(LANES + 1);

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic [LANES*ADDR_W-1:0] req_addr = '0;
    logic [LANES-1:0]        req_mask = '0;
    logic [1:0]              req_size = '0;
    logic                    txn_valid;
    logic                    txn_ready = 1'b0;
    logic [ADDR_W-1:0]       txn_line;
    logic [LANES-1:0]        txn_lanes;
    logic                    txn_last;
    logic                    done_valid;
    logic [CNT_W-1:0]        done_count;
    logic [LANES-1:0]        done_misalign;

    always #2 clk = ~clk;

    warp_coalescer u_warp_coalescer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask), .req_size(req_size),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_line(txn_line),
        .txn_lanes(txn_lanes), .txn_last(txn_last), .done_valid(done_valid),
        .done_count(done_count), .done_misalign(done_misalign)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    logic [31:0]      a [LANES];
    logic [LANES-1:0] m_v;
    logic [1:0]       s_v;
    logic [31:0]      exp_line [LANES];
    logic [LANES-1:0] exp_mask [LANES];
    int               exp_n;
    logic [LANES-1:0] exp_bad;
    int               got_count;
    logic [15:0]      lfsr = 16'hACE1;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Grouping model built from R2, R5, R6, R7.
    task automatic model();
        logic [LANES-1:0] pend;
        logic [31:0] lowm;
        exp_n = 0;
        exp_bad = '0;
        lowm = (s_v == 2'd0) ? 32'd3 : (s_v == 2'd1) ? 32'd7 : 32'd15;
        for (int i = 0; i < LANES; i++)
            if (m_v[i] && (s_v == 2'd3 || (a[i] & lowm) != 0)) exp_bad[i] = 1'b1;
        pend = m_v & ~exp_bad;
        while (pend != '0) begin
            int f;
            f = -1;
            for (int i = LANES - 1; i >= 0; i--) if (pend[i]) f = i;
            exp_line[exp_n] = a[f] & ~32'h7F;
            exp_mask[exp_n] = '0;
            for (int i = 0; i < LANES; i++)
                if (pend[i] && ((a[i] & ~32'h7F) == exp_line[exp_n])) exp_mask[exp_n][i] = 1'b1;
            pend &= ~exp_mask[exp_n];
            exp_n++;
        end
    endtask

    task automatic run(input string nm, input bit stall);
        int k;
        bit fin;
        bit held;
        logic [31:0] h_line;
        logic [LANES-1:0] h_lanes;
        model();
        @(negedge clk);
        chk(req_ready == 1'b1, {nm, " R9 idle ready"}, req_ready, 1);
        for (int i = 0; i < LANES; i++) req_addr[i*ADDR_W +: ADDR_W] = a[i];
        req_mask = m_v;
        req_size = s_v;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = {LANES{32'h0000_0041}};
        req_mask = '1;
        chk(req_ready == 1'b0, {nm, " R9 ready low after accept"}, req_ready, 0);
        k = 0; fin = 0; held = 0; got_count = -1;
        for (int t = 0; t < 300 && !fin; t++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            txn_ready = stall ? (lfsr[1:0] != 2'b00 ? 1'b0 : 1'b1) : 1'b1;
            #1;
            if (held) begin
                chk(txn_valid && txn_line == h_line && txn_lanes == h_lanes,
                    {nm, " R8 held while stalled"}, {txn_line, txn_lanes}, {h_line, h_lanes});
                held = 0;
            end
            if (txn_valid) begin
                if (k >= exp_n) begin
                    chk(1'b0, {nm, " R4 extra transaction"}, k + 1, exp_n);
                    fin = 1;
                end else if (txn_ready) begin
                    chk(txn_line == exp_line[k], {nm, " R2 R5 line"}, txn_line, exp_line[k]);
                    chk(txn_lanes == exp_mask[k], {nm, " R5 lanes"}, txn_lanes, exp_mask[k]);
                    chk(txn_last == (k == exp_n - 1), {nm, " R11 last flag"}, txn_last, k == exp_n - 1);
                    k++;
                end else begin
                    held = 1; h_line = txn_line; h_lanes = txn_lanes;
                end
            end
            if (done_valid) begin
                chk(k == exp_n, {nm, " R4 transactions seen"}, k, exp_n);
                chk(done_count == CNT_W'(exp_n), {nm, " R11 done count"}, done_count, exp_n);
                chk(done_misalign == exp_bad, {nm, " R6 R7 misalign mask"}, done_misalign, exp_bad);
                got_count = done_count;
                fin = 1;
            end
            @(negedge clk);
        end
        chk(fin, {nm, " R9 request completed"}, fin, 1);
        txn_ready = 1'b0;
        #1;
        chk(req_ready == 1'b1 && !done_valid, {nm, " R9 ready after done"}, req_ready, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        chk(!txn_valid && !done_valid, "R1 reset idle outputs", {txn_valid, done_valid}, 0);
    endtask

    task automatic t_coalesced();
        for (int i = 0; i < LANES; i++) a[i] = 32'h1000 + 4 * i;
        m_v = '1; s_v = 2'd0;
        run("coalesced R3", 0);
        chk(got_count == 1, "R3 single transaction", got_count, 1);
    endtask

    task automatic t_offset_run();
        for (int i = 0; i < LANES; i++) a[i] = 32'h1040 + 4 * i;
        m_v = '1; s_v = 2'd0;
        run("offset R4", 0);
        chk(got_count == 2, "R4 offset run two lines", got_count, 2);
    endtask

    task automatic t_stride();
        for (int i = 0; i < LANES; i++) a[i] = 32'h2000 + 12 * i;
        m_v = '1; s_v = 2'd0;
        run("stride12 R4", 0);
        chk(got_count == 3, "R4 stride three lines", got_count, 3);
    endtask

    task automatic t_sizes();
        for (int i = 0; i < LANES; i++) a[i] = 32'h3000 + 8 * i;
        m_v = '1; s_v = 2'd1;
        run("size8 R6", 0);
        chk(got_count == 2, "R6 8-byte two lines", got_count, 2);
        for (int i = 0; i < LANES; i++) a[i] = 32'h4000 + 16 * i;
        s_v = 2'd2;
        run("size16 R6", 0);
        chk(got_count == 4, "R6 16-byte four lines", got_count, 4);
    endtask

    task automatic t_misalign();
        for (int i = 0; i < LANES; i++) a[i] = 32'h7000 + 8 * i;
        a[3] = a[3] + 4; a[10] = a[10] + 4;
        m_v = '1; s_v = 2'd1;
        run("misalign R6", 0);
        chk(exp_bad == 32'h0000_0408, "R6 model bad lanes", exp_bad, 32'h408);
        for (int i = 0; i < LANES; i++) a[i] = 32'h1000 + 16 * i;
        s_v = 2'd3;
        run("reserved size R6", 0);
        chk(got_count == 0, "R6 reserved code issues nothing", got_count, 0);
    endtask

    task automatic t_order();
        for (int i = 0; i < LANES; i++) a[i] = 32'h6000 + (3 - (i % 4)) * 128 + 4 * (i / 4);
        m_v = '1; s_v = 2'd0;
        run("interleave R5", 0);
        chk(exp_line[0] == 32'h6180 && exp_mask[0] == 32'h1111_1111, "R5 first group", exp_line[0], 32'h6180);
    endtask

    task automatic t_partial();
        for (int i = 0; i < LANES; i++) a[i] = 32'hDEAD_BEE1;
        for (int i = 0; i < 4; i++) a[i] = 32'h8000 + 4 * i;
        for (int i = 12; i < 16; i++) a[i] = 32'h8100 + 4 * i;
        m_v = 32'h0000_F00F; s_v = 2'd0;
        run("partial R7", 0);
        chk(got_count == 2, "R7 inactive lanes ignored", got_count, 2);
    endtask

    task automatic t_empty();
        for (int i = 0; i < LANES; i++) a[i] = 32'h0000_0003;
        m_v = '0; s_v = 2'd0;
        run("empty R10", 0);
        chk(got_count == 0, "R10 empty request count", got_count, 0);
    endtask

    task automatic t_scatter_stall();
        for (int i = 0; i < LANES; i++) a[i] = 32'h9000 + 128 * i;
        m_v = '1; s_v = 2'd2;
        run("scatter R11", 1);
        chk(got_count == 32, "R11 full scatter count", got_count, 32);
        for (int i = 0; i < LANES; i++) a[i] = 32'h6000 + (3 - (i % 4)) * 128 + 4 * (i / 4);
        s_v = 2'd0;
        run("interleave stall R8", 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_coalesced();
        t_offset_run();
        t_stride();
        t_sizes();
        t_misalign();
        t_order();
        t_partial();
        t_empty();
        t_scatter_stall();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule